// File: doc/BRIEF.md
# Edge-Latched Interrupt Cause Unit

This block sits beside a serial flash controller and converts that controller's level status flags into sticky interrupt causes. Each flag is watched for a low-to-high transition. A transition latches the matching cause bit. The bit stays set until software writes a one to it.

A mask word selects which causes may reach the single interrupt line. The line is a registered OR of the enabled causes. Because only transitions latch, a flag that is already high when software clears its cause or opens its mask raises nothing. Software must therefore read the flag level directly before it waits for an interrupt.

Software reaches the block through two write strobes, one for cause clearing and one for the mask, which share a data bus. A one-bit select chooses whether the read bus shows the cause word or the mask word. The status inputs are generated elsewhere.

Top module: `irq_cause_unit`

## Requirements
- R1: A 0-to-1 transition on status bit i, sampled at a clock edge, sets cause bit i at that edge. Cause bit i always corresponds to status bit i (bit 0 is transfer done, up to bit 12, address not configured).
- R2: A status bit that stays high sets its cause bit at most once. After the cause is cleared, it stays clear for as long as the level remains high.
- R3: On a cause write (`wr_cause_i`=1), every cause bit whose data bit is 1 is cleared. Cause bits whose data bit is 0 keep their value.
- R4: A cause write with all data bits set clears every cause bit.
- R5: If a rising transition and a clearing write hit the same cause bit at the same edge, the bit ends up set.
- R6: Writing 0 to the mask (`wr_mask_i`=1) drives the interrupt low one cycle later and leaves every latched cause bit unchanged.
- R7: `irq_o` equals the OR of (cause AND mask) as held in the previous cycle, so it changes one clock after the cause or mask changes.
- R8: While `rst_ni` is low, all causes, the mask and `irq_o` are 0. Status bits that are already high when reset is released do not set any cause.
- R9: `rd_data_o` shows the cause word when `rd_sel_i`=0 and the mask word when `rd_sel_i`=1. Each word is zero-extended, so bits above the source count read as 0.
- R10: A status bit that is high while its cause is clear and its mask is opened produces no interrupt until the bit falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | N_SRC | Level status flags from the controller |
| wr_cause_i | input | 1 | Write-one-to-clear strobe for the cause word |
| wr_mask_i | input | 1 | Write strobe for the mask word |
| wr_data_i | input | DATA_W | Write data shared by both strobes |
| rd_sel_i | input | 1 | Read select: 0 for cause, 1 for mask |
| rd_data_o | output | DATA_W | Read data, zero-extended |
| cause_o | output | N_SRC | Latched cause bits |
| mask_o | output | N_SRC | Mask bits |
| irq_o | output | 1 | Registered interrupt line |

## Verification
On every cycle, the assertions check four things against a shadow copy of the previous status:
- every rising transition lands in the cause word;
- no cause bit rises without a transition;
- cause bits hold when no clearing write occurs;
- the interrupt line follows the previous cycle's masked causes.

Some behaviours appear only in the directed scenarios. These are the write-one-to-clear patterns, the set-over-clear collision, and the quiet start with status already high at reset release. They also include the case that defines this block: a level that is high at unmask time stays silent until it toggles.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned DEF_N_SRC  = 13;
  localparam int unsigned DEF_DATA_W = 32;

  typedef enum logic {
    RD_CAUSE = 1'b0,
    RD_MASK  = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] status_i,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] prev_q;
  logic             primed_q;

  // First cycle after reset only loads prev_q, so a level already high is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= status_i;
      primed_q <= 1'b1;
    end
  end

  assign rise_o = primed_q ? (status_i & ~prev_q) : '0;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] rise_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_bits_i,
  output logic [N_SRC-1:0] cause_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       bit_q <= 1'b0;
      else if (rise_i[g])                bit_q <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_bits_i[g]) bit_q <= 1'b0;
    end
    assign cause_o[g] = bit_q;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic [N_SRC-1:0] cause_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] mask_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(cause_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int unsigned N_SRC  = DEF_N_SRC,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  status_i,
  input  logic              wr_cause_i,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_SRC-1:0]  cause_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] cause;
  logic [N_SRC-1:0] mask;
  rd_sel_e          rsel;

  irq_edge_det #(.N_SRC(N_SRC)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .rise_o   (rise)
  );

  irq_cause_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .clr_we_i   (wr_cause_i),
    .clr_bits_i (wr_data_i[N_SRC-1:0]),
    .cause_o    (cause)
  );

  irq_out_stage #(.N_SRC(N_SRC)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (wr_mask_i),
    .mask_wdata_i (wr_data_i[N_SRC-1:0]),
    .cause_i      (cause),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  assign rsel = rd_sel_e'(rd_sel_i);

  always_comb begin
    unique case (rsel)
      RD_MASK: rd_data_o = {{PAD_W{1'b0}}, mask};
      default: rd_data_o = {{PAD_W{1'b0}}, cause};
    endcase
  end

  assign cause_o = cause;
  assign mask_o  = mask;
endmodule

// File: rtl/irq_cause_unit_chk.sv
module irq_cause_unit_chk #(
  parameter int unsigned N_SRC  = 13,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  status_i,
  input logic              wr_cause_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [N_SRC-1:0]  cause_o,
  input logic [N_SRC-1:0]  mask_o,
  input logic              irq_o
);
  logic [N_SRC-1:0] shadow_q;
  logic             armed_q;
  logic [N_SRC-1:0] exp_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      shadow_q <= status_i;
      armed_q  <= 1'b1;
    end
  end

  assign exp_rise = armed_q ? (status_i & ~shadow_q) : '0;

  p_rise_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (|exp_rise)) |=> ((cause_o & $past(exp_rise)) == $past(exp_rise)));

  p_no_spurious_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (((cause_o & ~$past(cause_o)) & ~$past(exp_rise)) == '0));

  p_clear_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr_cause_i) |=>
      ((cause_o & $past(wr_data_i[N_SRC-1:0] & ~exp_rise)) == '0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !wr_cause_i) |=> (cause_o == ($past(cause_o) | $past(exp_rise))));

  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (irq_o == $past(|(cause_o & mask_o))));

  always_comb begin
    if (rst_ni) begin
      p_read_pad_r9: assert (rd_data_o[DATA_W-1:N_SRC] == '0);
    end
  end
endmodule

bind irq_cause_unit irq_cause_unit_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_i),
  .wr_cause_i (wr_cause_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .cause_o    (cause_o),
  .mask_o     (mask_o),
  .irq_o      (irq_o)
);

// File: tb/irq_cause_unit_test.sv
`timescale 1ns/1ps
module irq_cause_unit_test;
  localparam int N = 13;
  localparam int W = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  status_i = '0;
  logic          wr_cause_i = 1'b0;
  logic          wr_mask_i = 1'b0;
  logic [W-1:0]  wr_data_i = '0;
  logic          rd_sel_i = 1'b0;
  logic [W-1:0]  rd_data_o;
  logic [N-1:0]  cause_o;
  logic [N-1:0]  mask_o;
  logic          irq_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  irq_cause_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_i),
    .wr_cause_i(wr_cause_i), .wr_mask_i(wr_mask_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .cause_o(cause_o),
    .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic write_mask(input logic [W-1:0] v);
    wr_mask_i = 1'b1; wr_data_i = v;
    step(1);
    wr_mask_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic write_clear(input logic [W-1:0] v);
    wr_cause_i = 1'b1; wr_data_i = v;
    step(1);
    wr_cause_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic t_reset;  // R8
    status_i = 13'h0005;
    step(3);
    chk("R8 cause in reset", W'(cause_o), 0);
    chk("R8 irq in reset", W'(irq_o), 0);
    rst_ni = 1'b1;
    step(3);
    chk("R8 no cause from high status at release", W'(cause_o), 0);
    chk("R8 mask after reset", W'(mask_o), 0);
    status_i = '0;
    step(1);
  endtask

  task automatic t_edge;  // R1 R7 R2
    write_mask(32'h3);
    status_i = 13'h0001;
    step(1);
    chk("R1 cause bit0 set", W'(cause_o), 32'h1);
    chk("R7 irq not yet", W'(irq_o), 0);
    step(1);
    chk("R7 irq one cycle later", W'(irq_o), 1);
    write_clear(32'h1);
    chk("R3 cause cleared", W'(cause_o), 0);
    chk("R7 irq lags clear", W'(irq_o), 1);
    step(1);
    chk("R7 irq drops", W'(irq_o), 0);
    step(3);
    chk("R2 held level does not relatch", W'(cause_o), 0);
    status_i = '0;
    step(1);
  endtask

  task automatic t_partial_clear;  // R3
    write_mask(32'h0);
    status_i = 13'h002A;
    step(1);
    chk("R1 three bits set", W'(cause_o), 32'h2A);
    status_i = '0;
    write_clear(32'h8);
    chk("R3 only written bit cleared", W'(cause_o), 32'h22);
  endtask

  task automatic t_clear_all;  // R4
    write_clear(32'hFFFF_FFFF);
    chk("R4 all causes cleared", W'(cause_o), 0);
  endtask

  task automatic t_set_wins;  // R5
    status_i = 13'h0004;
    step(1);
    status_i = '0;
    step(1);
    chk("R5 setup cause bit2", W'(cause_o), 32'h4);
    status_i = 13'h0004;
    write_clear(32'h4);
    chk("R5 set wins over clear", W'(cause_o), 32'h4);
    status_i = '0;
    write_clear(32'h4);
    chk("R5 later clear works", W'(cause_o), 0);
  endtask

  task automatic t_mask_off;  // R6
    write_mask(32'h1FFF);
    status_i = 13'h0080;
    step(2);
    chk("R6 irq before mask off", W'(irq_o), 1);
    write_mask(32'h0);
    chk("R6 mask zero", W'(mask_o), 0);
    chk("R6 cause kept", W'(cause_o), 32'h80);
    step(1);
    chk("R6 irq low", W'(irq_o), 0);
    chk("R6 cause still kept", W'(cause_o), 32'h80);
    status_i = '0;
    write_clear(32'h80);
  endtask

  task automatic t_high_unmask;  // R10
    status_i = 13'h0010;
    step(1);
    write_clear(32'h10);
    write_mask(32'h10);
    step(3);
    chk("R10 cause stays clear at high level", W'(cause_o), 0);
    chk("R10 no irq from standing level", W'(irq_o), 0);
    status_i = '0;
    step(1);
    status_i = 13'h0010;
    step(2);
    chk("R10 irq after fresh edge", W'(irq_o), 1);
    write_clear(32'h10);
    status_i = '0;
    write_mask(32'h0);
  endtask

  task automatic t_readback;  // R9
    status_i = 13'h1000;
    step(1);
    write_mask(32'hFFFF_FFFF);
    rd_sel_i = 1'b0;
    #1;
    chk("R9 cause read at bit12", rd_data_o, 32'h1000);
    rd_sel_i = 1'b1;
    #1;
    chk("R9 mask read zero-extended", rd_data_o, 32'h1FFF);
    rd_sel_i = 1'b0;
    status_i = '0;
    write_clear(32'hFFFF_FFFF);
    write_mask(32'h0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_edge();
    t_partial_clear();
    t_clear_all();
    t_set_wins();
    t_mask_off();
    t_high_unmask();
    t_readback();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule